// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block turns a bank of parallel audio words into a time-division multiplexed serial stream. A frame carries eight sample slots, one left and one right word for each of four channel pairs. The block produces the bit clock, the frame-sync line and the serial data line from a single system clock. Each bit clock period lasts two system clocks: one low and one high. Serial data changes as the bit clock falls and is meant to be sampled as it rises, most significant bit first.

Three framing flavours are supported: I2S-style, left-justified and right-justified. A separate option, half-frame sync, is independent of the flavour. When it is off, slots go out pair by pair and frame sync is a one-slot marker. When it is on, all left words go first and all right words follow, and frame sync shows the side for a whole half frame. The sample width and the slot width can be changed at run time up to a fixed maximum. Every setting and every sample word is captured at a frame boundary, and a one-cycle request pulse then asks for the next frame's words.

The controller is a three-state machine. IDLE is held during reset. The LOAD_START transition (IDLE to BIT_LOW) captures the first frame on the first clock after reset. In BIT_LOW the bit clock is low and the next bit is on the line. The RISE transition (BIT_LOW to BIT_HIGH) raises the bit clock. The FALL transition (BIT_HIGH to BIT_LOW) moves on to the next bit, and at the end of a frame it also captures new words and settings.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While reset is held, `bclk`, `fsync`, `sdata` and `data_req` are all 0. The first frame starts on the first clock edge after reset is released.
- R2: `bclk` is low for one `clk` cycle and then high for one `clk` cycle. `sdata` and `fsync` only change on the cycle in which `bclk` goes low.
- R3: With `cfg_half` = 0, slot s carries channel s/2, side s%2, where side 0 is left. Word index 2*ch+side is read from `tx_data[idx*MAX_W +: MAX_W]`. The sample is held in the low `cfg_samp_len` bits of that word, and higher bits are ignored.
- R4: With `cfg_half` = 1, slots 0 to 3 carry the left words of channels 0 to 3, and slots 4 to 7 carry the right words of channels 0 to 3.
- R5: With `cfg_half` = 0, before inversion, frame sync sits at its left level for exactly one slot time, marking slot 0, and at the opposite level for the rest of the frame.
- R6: With `cfg_half` = 1, before inversion, frame sync sits at its left level for slots 0 to 3 and at the opposite level for slots 4 to 7. This gives one transition at mid-frame.
- R7: `cfg_fmt` encoding: 0 is I2S-style, 1 is left-justified, 2 is right-justified, and 3 acts as left-justified. In I2S-style the left level is 0, so left data follows a falling edge. Each frame-sync transition comes one bit before the slot boundary it marks, so the MSB appears one bit clock after the edge. In the other flavours the left level is 1 and the edges align with the slot boundaries.
- R8: For left-justified and I2S-style framing, the sample MSB is on the first bit of its slot. Slot bits after the sample are 0.
- R9: For right-justified framing, the sample LSB is on the last bit of its slot. Slot bits before the sample are 0.
- R10: `cfg_fs_inv` = 1 inverts `fsync`. It does not change the data or the slot order.
- R11: Sample words are captured at the start of every frame. `data_req` is high for exactly the first `clk` cycle of every frame, and input changes after that cycle do not affect the frame in progress.
- R12: Changes to `cfg_fmt`, `cfg_half`, `cfg_fs_inv`, `cfg_samp_len` or `cfg_slot_len` made in the middle of a frame take effect only from the next frame. Legal lengths satisfy 1 <= samp_len <= slot_len <= MAX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Framing flavour (0 I2S-style, 1 left, 2 right, 3 left) |
| cfg_half | input | 1 | Half-frame sync and side-grouped slot order |
| cfg_fs_inv | input | 1 | Invert frame sync |
| cfg_samp_len | input | LEN_W | Sample width in bits |
| cfg_slot_len | input | LEN_W | Slot width in bits |
| tx_data | input | 2*PAIRS*MAX_W | Parallel sample words, word index 2*ch+side |
| data_req | output | 1 | One-cycle pulse: frame captured, next words wanted |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The stream is tried with pair-interleaved and side-grouped slot orders under each framing flavour. This separates a wrong slot-to-word mapping from a wrong bit placement inside a slot. Slot widths both equal to and wider than the sample, including a one-bit slot and an odd-width slot, expose padding and justification errors and off-by-one frame-sync advance. Words carry random bits above the sample width to catch unmasked bits. New words arrive right after each request and new settings arrive mid-frame, which shows whether capture happens only at the frame boundary.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ   = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BIT_LOW  = 2'd1,
        ST_BIT_HIGH = 2'd2
    } st_e;

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
    import tdm_tx_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int LEN_W   = 6,
    parameter int SLOT_IW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_fmt,
    input  logic               cfg_half,
    input  logic               cfg_fs_inv,
    input  logic [LEN_W-1:0]   cfg_samp_len,
    input  logic [LEN_W-1:0]   cfg_slot_len,
    output logic               load,
    output logic               active,
    output logic               bclk,
    output logic               last_bit,
    output logic [SLOT_IW-1:0] slot_idx,
    output logic [LEN_W-1:0]   bit_idx,
    output fmt_e               fmt_q,
    output logic               half_q,
    output logic               inv_q,
    output logic [LEN_W-1:0]   samp_len_q,
    output logic [LEN_W-1:0]   slot_len_q,
    output logic               data_req
);

    st_e st_q;
    st_e st_d;
    logic last_slot;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     st_d = ST_BIT_LOW;   // LOAD_START
            ST_BIT_LOW:  st_d = ST_BIT_HIGH;  // RISE
            ST_BIT_HIGH: st_d = ST_BIT_LOW;   // FALL
            default:     st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign last_bit  = (bit_idx == slot_len_q - LEN_W'(1));
    assign last_slot = (slot_idx == SLOT_IW'(SLOTS - 1));
    assign load      = (st_q == ST_IDLE) || ((st_q == ST_BIT_HIGH) && last_bit && last_slot);

    // Position counters and frame-boundary configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx   <= '0;
            bit_idx    <= '0;
            fmt_q      <= FMT_I2S;
            half_q     <= 1'b0;
            inv_q      <= 1'b0;
            samp_len_q <= LEN_W'(1);
            slot_len_q <= LEN_W'(1);
            data_req   <= 1'b0;
        end else begin
            data_req <= load;
            if (load) begin
                slot_idx   <= '0;
                bit_idx    <= '0;
                fmt_q      <= fmt_e'(cfg_fmt);
                half_q     <= cfg_half;
                inv_q      <= cfg_fs_inv;
                samp_len_q <= cfg_samp_len;
                slot_len_q <= cfg_slot_len;
            end else if (st_q == ST_BIT_HIGH) begin
                if (last_bit) begin
                    bit_idx  <= '0;
                    slot_idx <= last_slot ? '0 : slot_idx + SLOT_IW'(1);
                end else begin
                    bit_idx <= bit_idx + LEN_W'(1);
                end
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        bclk   = (st_q == ST_BIT_HIGH);
        active = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/tdm_tx_bank.sv
module tdm_tx_bank #(
    parameter int MAX_W   = 32,
    parameter int PAIRS   = 4,
    parameter int SLOT_IW = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       half_q,
    input  logic [SLOT_IW-1:0]         slot_idx,
    input  logic [2*PAIRS*MAX_W-1:0]   tx_data,
    output logic [MAX_W-1:0]           word
);

    localparam int SLOTS = 2 * PAIRS;

    logic [MAX_W-1:0]   words [SLOTS];
    logic [SLOT_IW-1:0] widx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)    words[g] <= '0;
            else if (load) words[g] <= tx_data[g*MAX_W +: MAX_W];
        end
    end

    // Slot to word mapping: pair-interleaved or side-grouped
    always_comb begin
        if (half_q)
            widx = SLOT_IW'((int'(slot_idx) % PAIRS) * 2 + int'(slot_idx) / PAIRS);
        else
            widx = slot_idx;
    end

    assign word = words[widx];

endmodule

// File: rtl/tdm_tx_bitsel.sv
module tdm_tx_bitsel
    import tdm_tx_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int LEN_W = 6
) (
    input  logic [MAX_W-1:0] word,
    input  logic [LEN_W-1:0] bit_idx,
    input  logic [LEN_W-1:0] samp_len_q,
    input  logic [LEN_W-1:0] slot_len_q,
    input  fmt_e             fmt_q,
    output logic             bit_out
);

    localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

    logic [LEN_W-1:0] lead;
    logic [LEN_W-1:0] pick;
    logic             in_sample;

    always_comb begin
        lead = slot_len_q - samp_len_q;
        if (fmt_q == FMT_RJ) begin
            in_sample = (bit_idx >= lead);
            pick      = slot_len_q - LEN_W'(1) - bit_idx;
        end else begin
            in_sample = (bit_idx < samp_len_q);
            pick      = samp_len_q - LEN_W'(1) - bit_idx;
        end
        bit_out = in_sample ? word[pick[IDX_W-1:0]] : 1'b0;
    end

endmodule

// File: rtl/tdm_tx_fsync.sv
module tdm_tx_fsync
    import tdm_tx_pkg::*;
#(
    parameter int PAIRS   = 4,
    parameter int SLOT_IW = 3
) (
    input  logic               active,
    input  logic               last_bit,
    input  logic [SLOT_IW-1:0] slot_idx,
    input  fmt_e               fmt_q,
    input  logic               half_q,
    input  logic               inv_q,
    output logic               fsync
);

    localparam int SLOTS = 2 * PAIRS;

    logic               i2s;
    logic [SLOT_IW-1:0] pslot;
    logic               left_side;
    logic               left_lvl;

    always_comb begin
        i2s = (fmt_q == FMT_I2S);
        // I2S-style framing leads the slot boundary by one bit
        if (i2s && last_bit)
            pslot = (slot_idx == SLOT_IW'(SLOTS - 1)) ? '0 : slot_idx + SLOT_IW'(1);
        else
            pslot = slot_idx;
        left_side = half_q ? (pslot < SLOT_IW'(PAIRS)) : (pslot == '0);
        left_lvl  = ~i2s;
        fsync     = active & ((left_side ? left_lvl : ~left_lvl) ^ inv_q);
    end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int PAIRS = 4,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_fmt,
    input  logic                     cfg_half,
    input  logic                     cfg_fs_inv,
    input  logic [LEN_W-1:0]         cfg_samp_len,
    input  logic [LEN_W-1:0]         cfg_slot_len,
    input  logic [2*PAIRS*MAX_W-1:0] tx_data,
    output logic                     data_req,
    output logic                     bclk,
    output logic                     fsync,
    output logic                     sdata
);

    localparam int SLOTS   = 2 * PAIRS;
    localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic               load;
    logic               active;
    logic               last_bit;
    logic [SLOT_IW-1:0] slot_idx;
    logic [LEN_W-1:0]   bit_idx;
    fmt_e               fmt_q;
    logic               half_q;
    logic               inv_q;
    logic [LEN_W-1:0]   samp_len_q;
    logic [LEN_W-1:0]   slot_len_q;
    logic [MAX_W-1:0]   word;
    logic               bit_out;

    tdm_tx_ctrl #(.SLOTS(SLOTS), .LEN_W(LEN_W), .SLOT_IW(SLOT_IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_fmt(cfg_fmt), .cfg_half(cfg_half), .cfg_fs_inv(cfg_fs_inv),
        .cfg_samp_len(cfg_samp_len), .cfg_slot_len(cfg_slot_len),
        .load(load), .active(active), .bclk(bclk), .last_bit(last_bit),
        .slot_idx(slot_idx), .bit_idx(bit_idx),
        .fmt_q(fmt_q), .half_q(half_q), .inv_q(inv_q),
        .samp_len_q(samp_len_q), .slot_len_q(slot_len_q),
        .data_req(data_req)
    );

    tdm_tx_bank #(.MAX_W(MAX_W), .PAIRS(PAIRS), .SLOT_IW(SLOT_IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(load), .half_q(half_q),
        .slot_idx(slot_idx), .tx_data(tx_data), .word(word)
    );

    tdm_tx_bitsel #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_bitsel (
        .word(word), .bit_idx(bit_idx), .samp_len_q(samp_len_q),
        .slot_len_q(slot_len_q), .fmt_q(fmt_q), .bit_out(bit_out)
    );

    tdm_tx_fsync #(.PAIRS(PAIRS), .SLOT_IW(SLOT_IW)) u_fsync (
        .active(active), .last_bit(last_bit), .slot_idx(slot_idx),
        .fmt_q(fmt_q), .half_q(half_q), .inv_q(inv_q), .fsync(fsync)
    );

    assign sdata = active & bit_out;

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker
    import tdm_tx_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int SLOT_IW = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bclk,
    input logic               fsync,
    input logic               sdata,
    input logic               data_req,
    input logic               active,
    input logic               load,
    input logic [SLOT_IW-1:0] slot_idx,
    input logic [LEN_W-1:0]   bit_idx,
    input fmt_e               fmt_q,
    input logic               half_q,
    input logic               inv_q,
    input logic [LEN_W-1:0]   samp_len_q,
    input logic [LEN_W-1:0]   slot_len_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!bclk && !sdata && !fsync && !data_req));

    p_bclk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bclk |=> !bclk);

    p_bclk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bclk) |=> bclk);

    p_hold_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> ($stable(sdata) && $stable(fsync)));

    p_lj_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fmt_q != FMT_RJ && bit_idx >= samp_len_q) |-> !sdata);

    p_rj_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fmt_q == FMT_RJ &&
         ({1'b0, bit_idx} + {1'b0, samp_len_q}) < {1'b0, slot_len_q}) |-> !sdata);

    p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |=> !data_req);

    p_req_at_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> (!bclk && slot_idx == '0 && bit_idx == '0));

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(fmt_q) && $stable(half_q) && $stable(inv_q) &&
                   $stable(samp_len_q) && $stable(slot_len_q)));

endmodule

bind tdm_tx_serializer tdm_tx_checker #(.LEN_W(LEN_W), .SLOT_IW(SLOT_IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
    .data_req(data_req), .active(active), .load(load),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .fmt_q(fmt_q), .half_q(half_q),
    .inv_q(inv_q), .samp_len_q(samp_len_q), .slot_len_q(slot_len_q)
);

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_W      = 32;
    localparam int PAIRS      = 4;
    localparam int SLOTS      = 2 * PAIRS;
    localparam int LEN_W      = $clog2(MAX_W + 1);
    localparam int NCFG       = 12;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [1:0]             cfg_fmt;
    logic                   cfg_half;
    logic                   cfg_fs_inv;
    logic [LEN_W-1:0]       cfg_samp_len;
    logic [LEN_W-1:0]       cfg_slot_len;
    logic [SLOTS*MAX_W-1:0] tx_data;
    logic                   data_req;
    logic                   bclk;
    logic                   fsync;
    logic                   sdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int t_fmt  [NCFG] = '{0, 0, 1, 1, 2, 2, 0, 1, 2, 0, 0, 3};
    int t_half [NCFG] = '{0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, 1};
    int t_inv  [NCFG] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
    int t_samp [NCFG] = '{16, 16, 12, 12, 12, 12, 24, 8, 5, 32, 1, 3};
    int t_slot [NCFG] = '{16, 16, 16, 16, 16, 16, 32, 8, 7, 32, 1, 3};

    logic [31:0] seed = 32'h1234_5678;
    logic [3:0]  exp_q [$];   // {bclk, sdata, fsync, data_req}
    string       sd_tag;
    string       fs_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_tx_serializer #(.MAX_W(MAX_W), .PAIRS(PAIRS)) u_tdm_tx_serializer (
        .clk(clk), .rst_n(rst_n),
        .cfg_fmt(cfg_fmt), .cfg_half(cfg_half), .cfg_fs_inv(cfg_fs_inv),
        .cfg_samp_len(cfg_samp_len), .cfg_slot_len(cfg_slot_len),
        .tx_data(tx_data), .data_req(data_req),
        .bclk(bclk), .fsync(fsync), .sdata(sdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_cfg(input int i);
        cfg_fmt      = 2'(t_fmt[i]);
        cfg_half     = 1'(t_half[i]);
        cfg_fs_inv   = 1'(t_inv[i]);
        cfg_samp_len = LEN_W'(t_samp[i]);
        cfg_slot_len = LEN_W'(t_slot[i]);
    endtask

    task automatic new_data();
        for (int i = 0; i < SLOTS; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            tx_data[i*MAX_W +: MAX_W] = seed;
        end
    endtask

    // Reference model: expected line values for one whole frame
    task automatic build_frame();
        int fmt, half, inv, len, smp, total;
        fmt   = int'(cfg_fmt);
        half  = int'(cfg_half);
        inv   = int'(cfg_fs_inv);
        len   = int'(cfg_slot_len);
        smp   = int'(cfg_samp_len);
        total = SLOTS * len;
        sd_tag = $sformatf("%s %s R12", half ? "R4" : "R3",
                           fmt == 0 ? "R7" : (fmt == 2 ? "R9" : "R8"));
        fs_tag = $sformatf("%s%s%s R12", half ? "R6" : "R5",
                           fmt == 0 ? " R7" : "", inv ? " R10" : "");
        for (int k = 0; k < total; k++) begin
            int s, b, ch, side, idx, pk, ps;
            logic [MAX_W-1:0] w;
            logic bv, fs, left_lvl, left_side;
            s = k / len;
            b = k % len;
            if (half != 0) begin ch = s % PAIRS; side = s / PAIRS; end
            else           begin ch = s / 2;     side = s % 2;     end
            idx = 2 * ch + side;
            w = tx_data[idx*MAX_W +: MAX_W];
            if (fmt == 2) bv = (b >= len - smp) ? w[len-1-b] : 1'b0;
            else          bv = (b < smp) ? w[smp-1-b] : 1'b0;
            pk = (fmt == 0) ? (k + 1) % total : k;
            ps = pk / len;
            left_side = (half != 0) ? (ps < PAIRS) : (ps == 0);
            left_lvl  = (fmt == 0) ? 1'b0 : 1'b1;
            fs = (left_side ? left_lvl : ~left_lvl) ^ 1'(inv);
            exp_q.push_back({1'b0, bv, fs, (k == 0)});
            exp_q.push_back({1'b1, bv, fs, 1'b0});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int frames, cfgi, fent;
        logic [3:0] e;
        rst_n = 1'b0;
        apply_cfg(0);
        new_data();
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        check(bclk == 1'b0,     "R1 bclk",     int'(bclk), 0);
        check(fsync == 1'b0,    "R1 fsync",    int'(fsync), 0);
        check(sdata == 1'b0,    "R1 sdata",    int'(sdata), 0);
        check(data_req == 1'b0, "R1 data_req", int'(data_req), 0);
        rst_n  = 1'b1;
        frames = 0;
        cfgi   = 0;
        fent   = 0;
        while (frames < NCFG || exp_q.size() != 0) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                build_frame();
                fent = exp_q.size();
                frames++;
            end
            e = exp_q.pop_front();
            check(bclk == e[3],     "R2 bclk",                int'(bclk), int'(e[3]));
            check(sdata == e[2],    {"sdata ", sd_tag},       int'(sdata), int'(e[2]));
            check(fsync == e[1],    {"fsync ", fs_tag},       int'(fsync), int'(e[1]));
            check(data_req == e[0], "R11 data_req",           int'(data_req), int'(e[0]));
            // R11: fresh words right after the request; frame in flight must keep old ones
            if (e[0]) new_data();
            // R12: next settings presented mid-frame, expected only from the next frame
            if (exp_q.size() == fent / 2 && cfgi + 1 < NCFG) begin
                cfgi++;
                apply_cfg(cfgi);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule